// File: doc/BRIEF.md
# DMA Channel Control and Status Core

This block is the control core of one DMA channel. Software programs it through two 32-bit registers: a mode word, which holds commands, interrupt enables and the pacing setting, and a status word, which holds event flags cleared by writing ones. From these it drives three plain control levels and pulses to a transfer datapath: run, pause and a one-cycle abort strobe. The datapath reports back per-byte progress, segment ends, link ends, chain completion and two kinds of error.

A channel starts on software command alone, or it can be armed to wait for an external start pin. When paced operation is enabled, the channel stops after a programmable power-of-two number of bytes. It resumes only on a fresh rising edge of a request pin, which is synchronised on entry. Abort moves a busy channel to a halted state, and the halted state counts as idle. All event flags, gated by their enables, are merged into one interrupt line. No data flows through this block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A mode write of all zeros returns the channel to idle from any state, clears the halted flag and clears the pacing byte counter. From the next cycle `xfer_go` and `xfer_pause` are low and status bits 6 (busy) and 5 (halted) read 0.
- R2: A mode write with bit 0 (start) set, bit 1 (abort) clear and bit 2 (external-start enable) clear, accepted while the channel is not busy, raises `xfer_go` and status bit 6 in the next cycle.
- R3: With bit 2 also set, the channel stays busy with `xfer_go` low until `ext_start` is seen high. After a two-flop synchroniser, `xfer_go` rises on the third clock edge after `ext_start` rises.
- R4: A start write is ignored while the channel is busy (waiting, running or paused), and the current state is kept.
- R5: A mode write with bit 1 set while busy stops the channel. In the next cycle `xfer_go` is low, `xfer_abort` is high for exactly one cycle, status bit 5 is 1 and bit 6 is 0. A later write that clears the start, external-start and abort bits (leaving the mode non-zero) keeps the channel halted. A start from the halted state is accepted.
- R6: The status read (`reg_addr`=1) returns busy on bit 6 and halted on bit 5. The channel is idle when bit 6 is 0 or bit 5 is 1.
- R7: Mode bits 27:24 hold log2 of the request count, clamped at 10 (1024 bytes). With mode bit 3 (external-pause enable) set and a non-zero value, the channel enters pause after that many `ev_byte` pulses counted since start or resume. A value of 0 disables pausing.
- R8: A paused channel resumes only on a low-to-high edge of the synchronised `dreq` that occurs while it is paused. A level held high from before the pause point does not resume it. Resume lands on the third edge after `dreq` rises.
- R9: Events set status bits: bit 0 segment end, bit 1 link end, bit 2 chain end, bit 3 programming error, bit 4 transfer error. A chain end while busy returns the channel to idle. A transfer error while busy halts it.
- R10: A status write clears each event bit whose write-data bit is 1. An event arriving in the same cycle keeps its bit set.
- R11: `irq` is high when bit 4 or bit 3 is set with mode bit 4 (error enable), or bit 0 with mode bit 5, or bit 1 with mode bit 6, or bit 2 with mode bit 7. The error bits raise `irq` through mode bit 4 and no other enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects mode, 1 selects status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ext_start | input | 1 | External start request (asynchronous) |
| dreq | input | 1 | External pacing request (asynchronous) |
| ev_byte | input | 1 | One byte moved by the datapath |
| ev_seg | input | 1 | Segment-end event |
| ev_link | input | 1 | Link-end event |
| ev_chain | input | 1 | Chain (transfer) end event |
| ev_perr | input | 1 | Programming error event |
| ev_terr | input | 1 | Transfer error event |
| xfer_go | output | 1 | Datapath may move data |
| xfer_pause | output | 1 | Channel paused awaiting request |
| xfer_abort | output | 1 | One-cycle abort strobe |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes and datapath events take effect at the clock edge that samples them. So control outputs, status reads and `irq` change one cycle later, and `xfer_abort` lasts exactly that one cycle. Changes on `ext_start` and `dreq` take three edges: two synchroniser stages, then the state register. The bench drives every input on a falling edge and samples on falling edges. For the pin-driven cases it checks one cycle before the due edge, to confirm nothing has moved yet, and again at the due edge itself.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RUN, ST_PAUSE, ST_HALT
  } chan_state_e;

  // mode word fields
  localparam int M_START  = 0;
  localparam int M_ABORT  = 1;
  localparam int M_XSTART = 2;
  localparam int M_XPAUSE = 3;
  localparam int M_IE_ERR = 4;
  localparam int M_IE_SEG = 5;
  localparam int M_IE_LNK = 6;
  localparam int M_IE_EOT = 7;
  localparam int M_RC_LO  = 24;
  localparam int RC_W     = 4;

  // status word fields
  localparam int S_SEG  = 0;
  localparam int S_LNK  = 1;
  localparam int S_EOT  = 2;
  localparam int S_PERR = 3;
  localparam int S_TERR = 4;
  localparam int S_HALT = 5;
  localparam int S_BUSY = 6;
  localparam int EV_W   = 5;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dcc_pace.sv
module dcc_pace #(
  parameter int MAX_LOG2 = 10,
  parameter int LOG_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             byte_ev,
  input  logic [LOG_W-1:0] log2_cnt,
  output logic             hit
);
  localparam int CW = MAX_LOG2;

  logic [LOG_W-1:0] eff;
  logic [CW:0]      span;
  logic [CW-1:0]    lim, cnt_q;
  logic             active;

  always_comb begin
    eff    = (log2_cnt > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : log2_cnt;
    span   = (CW+1)'(1) << eff;
    lim    = span[CW-1:0] - 1'b1;
    active = enable && (log2_cnt != '0);
    hit    = byte_ev && active && (cnt_q == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear)             cnt_q <= '0;
    else if (byte_ev && active) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  // R7: count never runs past the programmed limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && active && !clear && cnt_q == lim) |=> (cnt_q == '0));
endmodule

// File: rtl/dcc_status.sv
module dcc_status
  import dcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic            wr,
  input  logic [EV_W-1:0] wdata,
  input  logic            ie_err,
  input  logic            ie_seg,
  input  logic            ie_lnk,
  input  logic            ie_eot,
  output logic [EV_W-1:0] stat,
  output logic            irq
);
  logic [EV_W-1:0] clr;

  assign clr = wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | ev;
  end

  assign irq = (ie_err && (stat[S_TERR] || stat[S_PERR]))
             || (ie_seg && stat[S_SEG])
             || (ie_lnk && stat[S_LNK])
             || (ie_eot && stat[S_EOT]);

  p_w1c_seg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[S_SEG] && !ev[S_SEG]) |=> !stat[S_SEG]);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev[S_EOT] |=> stat[S_EOT]);
  p_err_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[S_TERR] && ie_err) |-> irq);
  p_quiet_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !irq);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dcc_pkg::*;
#(
  parameter int MAX_LOG2    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ext_start,
  input  logic        dreq,
  input  logic        ev_byte,
  input  logic        ev_seg,
  input  logic        ev_link,
  input  logic        ev_chain,
  input  logic        ev_perr,
  input  logic        ev_terr,
  output logic        xfer_go,
  output logic        xfer_pause,
  output logic        xfer_abort,
  output logic        irq
);
  chan_state_e     state_q, state_d;
  logic [31:0]     mode_q;
  logic            ext_s, dreq_s, dreq_d, dreq_rise;
  logic            wr_mode, wr_stat, busy, halted;
  logic            start_cmd, abort_cmd, zero_cmd, pace_hit, abort_q;
  logic [EV_W-1:0] ev_vec, stat;

  dcc_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
    .clk(clk), .rst_n(rst_n), .din(ext_start), .dout(ext_s));
  dcc_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk(clk), .rst_n(rst_n), .din(dreq), .dout(dreq_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_d <= 1'b0;
    else        dreq_d <= dreq_s;
  end
  assign dreq_rise = dreq_s && !dreq_d;

  assign wr_mode   = reg_wr && !reg_addr;
  assign wr_stat   = reg_wr && reg_addr;
  assign busy      = (state_q == ST_WAIT) || (state_q == ST_RUN) || (state_q == ST_PAUSE);
  assign halted    = (state_q == ST_HALT);
  assign zero_cmd  = wr_mode && (reg_wdata == '0);
  assign abort_cmd = wr_mode && reg_wdata[M_ABORT] && busy;
  assign start_cmd = wr_mode && reg_wdata[M_START] && !reg_wdata[M_ABORT] && !busy;

  dcc_pace #(.MAX_LOG2(MAX_LOG2), .LOG_W(RC_W)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_cmd || zero_cmd),
    .enable   (mode_q[M_XPAUSE]),
    .byte_ev  (ev_byte && (state_q == ST_RUN)),
    .log2_cnt (mode_q[M_RC_LO +: RC_W]),
    .hit      (pace_hit)
  );

  always_comb begin
    state_d = state_q;
    if (zero_cmd)                    state_d = ST_IDLE;
    else if (abort_cmd)              state_d = ST_HALT;
    else if (start_cmd)              state_d = reg_wdata[M_XSTART] ? ST_WAIT : ST_RUN;
    else if (busy && ev_terr)        state_d = ST_HALT;
    else if (busy && ev_chain)       state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_WAIT:  if (ext_s)     state_d = ST_RUN;
        ST_RUN:   if (pace_hit)  state_d = ST_PAUSE;
        ST_PAUSE: if (dreq_rise) state_d = ST_RUN;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_cmd;
      if (wr_mode) mode_q <= reg_wdata;
    end
  end

  always_comb begin
    ev_vec         = '0;
    ev_vec[S_SEG]  = ev_seg;
    ev_vec[S_LNK]  = ev_link;
    ev_vec[S_EOT]  = ev_chain;
    ev_vec[S_PERR] = ev_perr;
    ev_vec[S_TERR] = ev_terr;
  end

  dcc_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev_vec),
    .wr     (wr_stat),
    .wdata  (reg_wdata[EV_W-1:0]),
    .ie_err (mode_q[M_IE_ERR]),
    .ie_seg (mode_q[M_IE_SEG]),
    .ie_lnk (mode_q[M_IE_LNK]),
    .ie_eot (mode_q[M_IE_EOT]),
    .stat   (stat),
    .irq    (irq)
  );

  assign xfer_go    = (state_q == ST_RUN);
  assign xfer_pause = (state_q == ST_PAUSE);
  assign xfer_abort = abort_q;
  assign reg_rdata  = reg_addr ? {25'd0, busy, halted, stat} : mode_q;

  p_zero_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> (!xfer_go && !xfer_pause && !busy && !halted));
  p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !reg_wdata[M_XSTART]) |=> xfer_go);
  p_busy_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && busy && reg_wdata[M_START] && !reg_wdata[M_ABORT]
     && !ev_chain && !ev_terr) |=> busy);
  p_abort_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_cmd |=> (halted && !xfer_go && xfer_abort));
  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> !xfer_abort);
  p_pause_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_pause) |-> $past(ev_byte));
  p_resume_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pause && !dreq_rise && !wr_mode && !ev_chain && !ev_terr) |=> xfer_pause);
endmodule

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [31:0] MD_START = 32'h1, MD_ABORT = 32'h2, MD_XST = 32'h4,
                          MD_XPAU = 32'h8, MD_IEERR = 32'h10, MD_IESEG = 32'h20,
                          MD_IEEOT = 32'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ext_start = 1'b0, dreq = 1'b0;
  logic ev_byte = 1'b0, ev_seg = 1'b0, ev_link = 1'b0, ev_chain = 1'b0;
  logic ev_perr = 1'b0, ev_terr = 1'b0;
  logic xfer_go, xfer_pause, xfer_abort, irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_start(ext_start),
    .dreq(dreq), .ev_byte(ev_byte), .ev_seg(ev_seg), .ev_link(ev_link),
    .ev_chain(ev_chain), .ev_perr(ev_perr), .ev_terr(ev_terr),
    .xfer_go(xfer_go), .xfer_pause(xfer_pause), .xfer_abort(xfer_abort), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(logic addr, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_stat(output logic [31:0] v);
    reg_addr = 1'b1; #1; v = reg_rdata; reg_addr = 1'b0; #1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    check("R1 reset mode", reg_rdata, 32'h0);
    read_stat(s);
    check("R6 reset status", s, 32'h0);
    check("R1 reset go/pause/irq", {29'd0, xfer_go, xfer_pause, irq}, 32'h0);
  endtask

  task automatic t_plain_start;
    logic [31:0] s;
    write(1'b0, MD_START | MD_IEEOT);
    check("R2 go after start", {31'd0, xfer_go}, 32'h1);
    read_stat(s);
    check("R6 busy bit", s, 32'h40);
    write(1'b0, MD_START | MD_XST | MD_IEEOT);
    check("R4 start while busy ignored", {31'd0, xfer_go}, 32'h1);
    pulse(ev_link);
    read_stat(s);
    check("R9 link-end bit1", s, 32'h42);
    check("R11 link not enabled", {31'd0, irq}, 32'h0);
    pulse(ev_chain);
    check("R9 chain end stops go", {31'd0, xfer_go}, 32'h0);
    read_stat(s);
    check("R9 chain bit2, idle", s, 32'h06);
    check("R11 eot irq", {31'd0, irq}, 32'h1);
    write(1'b1, 32'h4);
    read_stat(s);
    check("R10 w1c chain only", s, 32'h02);
    check("R11 irq drops", {31'd0, irq}, 32'h0);
    write(1'b1, 32'h1F);
    write(1'b0, 32'h0);
  endtask

  task automatic t_ext_start;
    logic [31:0] s;
    write(1'b0, MD_START | MD_XST);
    check("R3 waits for pin", {31'd0, xfer_go}, 32'h0);
    read_stat(s);
    check("R3 busy while waiting", s, 32'h40);
    idle_cycles(3);
    check("R3 still waiting", {31'd0, xfer_go}, 32'h0);
    ext_start = 1'b1;
    idle_cycles(2);
    check("R3 not before third edge", {31'd0, xfer_go}, 32'h0);
    idle_cycles(1);
    check("R3 go on third edge", {31'd0, xfer_go}, 32'h1);
    ext_start = 1'b0;
    write(1'b0, 32'h0);
    check("R1 zero write idles", {30'd0, xfer_go, xfer_pause}, 32'h0);
  endtask

  task automatic t_pacing;
    write(1'b0, MD_START | MD_XPAU | (32'd2 << 24));
    pulse(ev_byte); pulse(ev_byte);
    dreq = 1'b1;
    pulse(ev_byte);
    check("R7 running before count", {30'd0, xfer_go, xfer_pause}, 32'h2);
    pulse(ev_byte);
    check("R7 paused after 4 bytes", {30'd0, xfer_go, xfer_pause}, 32'h1);
    idle_cycles(6);
    check("R8 held level no resume", {30'd0, xfer_go, xfer_pause}, 32'h1);
    dreq = 1'b0;
    idle_cycles(4);
    dreq = 1'b1;
    idle_cycles(2);
    check("R8 not before third edge", {30'd0, xfer_go, xfer_pause}, 32'h1);
    idle_cycles(1);
    check("R8 resume on fresh edge", {30'd0, xfer_go, xfer_pause}, 32'h2);
    dreq = 1'b0;
    write(1'b0, 32'h0);
    write(1'b0, MD_START | MD_XPAU);
    for (int i = 0; i < 5; i++) pulse(ev_byte);
    check("R7 zero count never pauses", {30'd0, xfer_go, xfer_pause}, 32'h2);
    write(1'b0, 32'h0);
  endtask

  task automatic t_abort;
    logic [31:0] s;
    write(1'b0, MD_START | MD_IEERR);
    write(1'b0, MD_START | MD_ABORT | MD_IEERR);
    check("R5 abort stops go, strobe", {30'd0, xfer_go, xfer_abort}, 32'h1);
    read_stat(s);
    check("R5 halted not busy", s, 32'h20);
    @(negedge clk);
    check("R5 strobe one cycle", {31'd0, xfer_abort}, 32'h0);
    write(1'b0, MD_IEERR);
    read_stat(s);
    check("R5 stays halted", s, 32'h20);
    write(1'b0, MD_START | MD_IEERR);
    check("R5 restart from halted", {31'd0, xfer_go}, 32'h1);
    write(1'b0, 32'h0);
    read_stat(s);
    check("R1 zero clears halted", s, 32'h0);
  endtask

  task automatic t_errors;
    logic [31:0] s;
    write(1'b0, MD_START | MD_IEERR);
    pulse(ev_seg);
    read_stat(s);
    check("R9 seg bit0", s, 32'h41);
    check("R11 seg not enabled", {31'd0, irq}, 32'h0);
    pulse(ev_terr);
    check("R9 error halts", {31'd0, xfer_go}, 32'h0);
    read_stat(s);
    check("R9 terr bit4 halted", s, 32'h31);
    check("R11 error irq", {31'd0, irq}, 32'h1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h1; ev_seg = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; ev_seg = 1'b0;
    read_stat(s);
    check("R10 set wins over clear", s, 32'h31);
    write(1'b1, 32'h1F);
    read_stat(s);
    check("R10 clear all events", s, 32'h20);
    check("R11 irq low after clear", {31'd0, irq}, 32'h0);
    pulse(ev_perr);
    read_stat(s);
    check("R9 perr bit3", s, 32'h28);
    check("R11 perr via error enable", {31'd0, irq}, 32'h1);
    write(1'b0, MD_IESEG);
    check("R11 perr ignores other enables", {31'd0, irq}, 32'h0);
    write(1'b1, 32'h1F);
    write(1'b0, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_start();
    t_ext_start();
    t_pacing();
    t_abort();
    t_errors();
    idle_cycles(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule